// File: doc/BRIEF.md
# Region-Tagged Translation Buffer with Key Protection

This block translates 64-bit virtual addresses to physical addresses through a small fully associative buffer. The three most significant address bits pick one of eight region registers. The region identifier held there forms the tag, together with the virtual page number. Several address regions can therefore share translations by holding the same identifier, or stay apart by holding different ones. Each entry has its own page size, chosen from ten sizes between 4 KB and 256 MB. The page size decides how many low address bits pass through untranslated.

A hit returns the physical address and a permission verdict. Three checks must all pass. The entry's own rights must allow the access type. The requester's privilege level must be high enough for the entry. A set of key registers must hold a valid key equal to the entry's key, with the right bit set for the access type. Software-side logic fills the region registers, the key registers and the entries. It can also invalidate a naturally aligned range of addresses, up to 4 GB, in one request. A lookup is answered one clock after it is presented.

Top module: `tlb_region_key`

## Requirements
- R1: The region register selected by lookup address bits 63:61 supplies the identifier compared with each entry. Two regions that hold the same identifier hit the same entry. Rewriting a region's identifier makes that region's earlier translations miss.
- R2: A lookup presented with `lkValid` high in one cycle is answered in the next cycle with `rspValid` high. A hit requires that the region identifier and the page number above the entry's page offset both match a valid entry. The physical address is the entry's page frame with the untranslated offset bits taken from the virtual address.
- R3: A lookup that matches no valid entry gives `rspMiss` high, `rspHit` low, `rspAllow` low and a zero address. Reset invalidates every entry and every key register. When no response is due, all response flags are low.
- R4: The entry page-size codes 0 to 9 give 12, 13, 14, 16, 18, 20, 22, 24, 26 and 28 offset bits, that is 4 KB to 256 MB. Codes 10 to 15 act as 4 KB.
- R5: The access type is encoded as 0 for read, 1 for write and 2 for execute; code 3 is never allowed. Rights fields use bit 0 for read, bit 1 for write and bit 2 for execute. An access is allowed only if some valid key register holds a key equal to the entry's key and has the rights bit for the access type set.
- R6: An access is allowed only if the matching entry's own rights bit for the access type is set.
- R7: An access is allowed only if the requesting privilege level is numerically no greater than the entry's level, with 0 as the most privileged.
- R8: When more than one valid entry matches, `rspMulti` and `rspHit` are high and `rspAllow` is low.
- R9: Insertions fill entry slots in round-robin order starting from slot 0 after reset. The seventeenth insertion therefore overwrites the first.
- R10: A purge uses the identifier of the region selected by purge address bits 63:61. It invalidates every valid entry with that identifier whose page overlaps the aligned range given by the purge size code. Codes 0 to 9 mean the same sizes as in R4, and codes 10 to 15 mean 4 GB. Other entries are left unchanged.
- R11: When an insertion and a purge happen in the same cycle, the purge acts first and the inserted entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| rrWe | input | 1 | Write a region register |
| rrIdx | input | 3 | Region register index |
| rrRid | input | RID_W (24) | Region identifier to write |
| keyWe | input | 1 | Write a key register |
| keyIdx | input | clog2(KEYS) (3) | Key register index |
| keyVal | input | KEY_W (24) | Key value |
| keyRights | input | 3 | Key rights: bit 0 read, bit 1 write, bit 2 execute |
| keyValid | input | 1 | Valid flag stored with the key |
| insValid | input | 1 | Insert an entry into the next round-robin slot |
| insVa | input | VA_W (64) | Virtual address of the page to insert |
| insPs | input | 4 | Page-size code of the entry |
| insPpn | input | PA_W-12 (36) | Physical frame number in 4 KB units |
| insRights | input | 3 | Entry rights: bit 0 read, bit 1 write, bit 2 execute |
| insPl | input | 2 | Least privileged level allowed to use the entry |
| insKey | input | KEY_W (24) | Protection key of the entry |
| purgeValid | input | 1 | Purge request |
| purgeVa | input | VA_W (64) | Address inside the range to purge |
| purgePs | input | 4 | Purge size code |
| lkValid | input | 1 | Lookup request |
| lkVa | input | VA_W (64) | Virtual address to translate |
| lkAccess | input | 2 | Access type: 0 read, 1 write, 2 execute |
| lkPl | input | 2 | Current privilege level |
| rspValid | output | 1 | Response for the previous cycle's lookup |
| rspHit | output | 1 | At least one entry matched |
| rspMiss | output | 1 | No entry matched |
| rspMulti | output | 1 | More than one entry matched |
| rspAllow | output | 1 | Access permitted |
| rspPa | output | PA_W (48) | Translated physical address |

## Verification
The assertions check on every cycle that each lookup gets exactly one response, one cycle later. They also check that hit and miss exclude each other, that permission is never granted without a single clean hit, that a multiple match is always denied, and that the low 12 address bits pass through on a hit. The bench scenarios are the only place the table contents can be shown. These cover shared and separated region identifiers, offset masking for large pages, each permission check failing on its own, and purges that hit or spare an entry by range and region. They also cover slot reuse in round-robin order and a purge coinciding with an insertion.

// File: rtl/tlb_region_key_pkg.sv
package tlb_region_key_pkg;

  // Per-cycle actions the control hands to the datapath.
  typedef struct packed {
    logic rrWrite;
    logic keyWrite;
    logic insert;
    logic purge;
    logic lookup;
  } tlbStrobes_t;

  // Offset bits for an entry page-size code; unknown codes fall back to 4 KB.
  function automatic int unsigned pageShift(input logic [3:0] code);
    case (code)
      4'd0:    return 12;
      4'd1:    return 13;
      4'd2:    return 14;
      4'd3:    return 16;
      4'd4:    return 18;
      4'd5:    return 20;
      4'd6:    return 22;
      4'd7:    return 24;
      4'd8:    return 26;
      4'd9:    return 28;
      default: return 12;
    endcase
  endfunction

  // Range bits for a purge size code; codes 10 and up cover 4 GB.
  function automatic int unsigned purgeShift(input logic [3:0] code);
    if (code >= 4'd10) return 32;
    return pageShift(code);
  endfunction

endpackage

// File: rtl/tlb_region_key_ctrl.sv
module tlb_region_key_ctrl
  import tlb_region_key_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rrWe,
  input  logic              keyWe,
  input  logic              insValid,
  input  logic              purgeValid,
  input  logic              lkValid,
  output tlbStrobes_t       strobes,
  output logic [SLOT_W-1:0] insSlot,
  output logic              rspValid
);

  logic [SLOT_W-1:0] nextSlot;

  always_comb begin
    strobes          = '0;
    strobes.rrWrite  = rrWe;
    strobes.keyWrite = keyWe;
    strobes.insert   = insValid;
    strobes.purge    = purgeValid;
    strobes.lookup   = lkValid;
  end

  // Round-robin victim pointer, advanced by every insertion.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextSlot <= '0;
    end else if (insValid) begin
      if (nextSlot == SLOT_W'(ENTRIES - 1)) nextSlot <= '0;
      else                                  nextSlot <= nextSlot + 1'b1;
    end
  end

  assign insSlot = nextSlot;

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= lkValid;
  end

endmodule

// File: rtl/tlb_region_key_dp.sv
module tlb_region_key_dp
  import tlb_region_key_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int PA_W    = 48,
  parameter int RID_W   = 24,
  parameter int KEY_W   = 24,
  parameter int ENTRIES = 16,
  parameter int KEYS    = 8,
  localparam int REGION_BITS = 3,
  localparam int REGIONS     = 1 << REGION_BITS,
  localparam int VPN_W       = VA_W - REGION_BITS - 12,
  localparam int PPN_W       = PA_W - 12,
  localparam int SLOT_W      = $clog2(ENTRIES),
  localparam int KIDX_W      = $clog2(KEYS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tlbStrobes_t            strobes,
  input  logic [SLOT_W-1:0]      insSlot,
  input  logic [REGION_BITS-1:0] rrIdx,
  input  logic [RID_W-1:0]       rrRid,
  input  logic [KIDX_W-1:0]      keyIdx,
  input  logic [KEY_W-1:0]       keyVal,
  input  logic [2:0]             keyRights,
  input  logic                   keyValid,
  input  logic [VA_W-1:0]        insVa,
  input  logic [3:0]             insPs,
  input  logic [PPN_W-1:0]       insPpn,
  input  logic [2:0]             insRights,
  input  logic [1:0]             insPl,
  input  logic [KEY_W-1:0]       insKey,
  input  logic [VA_W-1:0]        purgeVa,
  input  logic [3:0]             purgePs,
  input  logic [VA_W-1:0]        lkVa,
  input  logic [1:0]             lkAccess,
  input  logic [1:0]             lkPl,
  output logic                   rspHit,
  output logic                   rspMiss,
  output logic                   rspMulti,
  output logic                   rspAllow,
  output logic [PA_W-1:0]        rspPa
);

  // Region registers
  logic [RID_W-1:0] regionRid [REGIONS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < REGIONS; r++) regionRid[r] <= '0;
    end else if (strobes.rrWrite) begin
      regionRid[rrIdx] <= rrRid;
    end
  end

  // Key registers
  logic             keyLive   [KEYS];
  logic [KEY_W-1:0] keyStore  [KEYS];
  logic [2:0]       keyPerm   [KEYS];

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rstN) begin
        keyLive[k] <= 1'b0;
      end else if (strobes.keyWrite && keyIdx == KIDX_W'(k)) begin
        keyLive[k] <= keyValid;
      end
    end
    always_ff @(posedge clk) begin
      if (strobes.keyWrite && keyIdx == KIDX_W'(k)) begin
        keyStore[k] <= keyVal;
        keyPerm[k]  <= keyRights;
      end
    end
  end

  // Entry storage
  logic             entValid  [ENTRIES];
  logic [RID_W-1:0] entRid    [ENTRIES];
  logic [VPN_W-1:0] entVpn    [ENTRIES];
  logic [3:0]       entPs     [ENTRIES];
  logic [PPN_W-1:0] entPpn    [ENTRIES];
  logic [2:0]       entRights [ENTRIES];
  logic [1:0]       entPl     [ENTRIES];
  logic [KEY_W-1:0] entKey    [ENTRIES];

  logic [RID_W-1:0] insRid, lkRid, prRid;
  logic [VPN_W-1:0] insVpn, lkVpn, prVpn;
  logic [ENTRIES-1:0] lkMatch, prMatch;
  logic unusedLowBits;

  assign insRid = regionRid[insVa[VA_W-1 -: REGION_BITS]];
  assign lkRid  = regionRid[lkVa[VA_W-1 -: REGION_BITS]];
  assign prRid  = regionRid[purgeVa[VA_W-1 -: REGION_BITS]];
  assign insVpn = insVa[VA_W-REGION_BITS-1:12];
  assign lkVpn  = lkVa[VA_W-REGION_BITS-1:12];
  assign prVpn  = purgeVa[VA_W-REGION_BITS-1:12];
  assign unusedLowBits = ^{insVa[11:0], purgeVa[11:0]};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    int unsigned      eShift;
    int unsigned      pShift;
    logic [VPN_W-1:0] lkMask;
    logic [VPN_W-1:0] prMask;

    always_comb begin
      eShift = pageShift(entPs[e]);
      pShift = purgeShift(purgePs);
      if (eShift > pShift) pShift = eShift;
      lkMask = {VPN_W{1'b1}} << (eShift - 12);
      prMask = {VPN_W{1'b1}} << (pShift - 12);
    end

    assign lkMatch[e] = entValid[e] && (entRid[e] == lkRid) &&
                        (((entVpn[e] ^ lkVpn) & lkMask) == '0);
    assign prMatch[e] = entValid[e] && (entRid[e] == prRid) &&
                        (((entVpn[e] ^ prVpn) & prMask) == '0);

    // Purge clears first; an insertion in the same cycle wins its slot.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[e] <= 1'b0;
      end else if (strobes.insert && insSlot == SLOT_W'(e)) begin
        entValid[e] <= 1'b1;
      end else if (strobes.purge && prMatch[e]) begin
        entValid[e] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (strobes.insert && insSlot == SLOT_W'(e)) begin
        entRid[e]    <= insRid;
        entVpn[e]    <= insVpn;
        entPs[e]     <= insPs;
        entPpn[e]    <= insPpn;
        entRights[e] <= insRights;
        entPl[e]     <= insPl;
        entKey[e]    <= insKey;
      end
    end
  end

  // Lowest matching slot and multiple-match detection
  logic [SLOT_W-1:0] selIdx;
  logic              anyMatch;
  logic              multiMatch;

  always_comb begin
    selIdx     = '0;
    anyMatch   = 1'b0;
    multiMatch = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lkMatch[e]) begin
        if (anyMatch) multiMatch = 1'b1;
        else          selIdx = SLOT_W'(e);
        anyMatch = 1'b1;
      end
    end
  end

  // Permission evaluation on the selected entry
  logic [2:0]       accOneHot;
  logic             entRightOk;
  logic             keyOk;
  logic             plOk;
  logic [KEY_W-1:0] selKey;

  always_comb begin
    case (lkAccess)
      2'd0:    accOneHot = 3'b001;
      2'd1:    accOneHot = 3'b010;
      2'd2:    accOneHot = 3'b100;
      default: accOneHot = 3'b000;
    endcase
  end

  assign selKey     = entKey[selIdx];
  assign entRightOk = |(entRights[selIdx] & accOneHot);
  assign plOk       = lkPl <= entPl[selIdx];

  always_comb begin
    keyOk = 1'b0;
    for (int k = 0; k < KEYS; k++) begin
      if (keyLive[k] && keyStore[k] == selKey && |(keyPerm[k] & accOneHot))
        keyOk = 1'b1;
    end
  end

  // Address assembly: offset bits bypass translation
  int unsigned     selShift;
  logic [PA_W-1:0] offMask;
  logic [PA_W-1:0] frameAddr;
  logic [PA_W-1:0] physAddr;

  assign selShift  = pageShift(entPs[selIdx]);
  assign offMask   = ~({PA_W{1'b1}} << selShift);
  assign frameAddr = {entPpn[selIdx], 12'b0};
  assign physAddr  = (frameAddr & ~offMask) | (lkVa[PA_W-1:0] & offMask);

  // Response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspMulti <= 1'b0;
      rspAllow <= 1'b0;
      rspPa    <= '0;
    end else if (strobes.lookup) begin
      rspHit   <= anyMatch;
      rspMiss  <= ~|lkMatch;
      rspMulti <= multiMatch;
      rspAllow <= anyMatch && !multiMatch && entRightOk && keyOk && plOk;
      rspPa    <= anyMatch ? physAddr : '0;
    end else begin
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspMulti <= 1'b0;
      rspAllow <= 1'b0;
      rspPa    <= '0;
    end
  end

endmodule

// File: rtl/tlb_region_key.sv
module tlb_region_key
  import tlb_region_key_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int PA_W    = 48,
  parameter int RID_W   = 24,
  parameter int KEY_W   = 24,
  parameter int ENTRIES = 16,
  parameter int KEYS    = 8,
  localparam int PPN_W  = PA_W - 12,
  localparam int KIDX_W = $clog2(KEYS),
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rrWe,
  input  logic [2:0]        rrIdx,
  input  logic [RID_W-1:0]  rrRid,
  input  logic              keyWe,
  input  logic [KIDX_W-1:0] keyIdx,
  input  logic [KEY_W-1:0]  keyVal,
  input  logic [2:0]        keyRights,
  input  logic              keyValid,
  input  logic              insValid,
  input  logic [VA_W-1:0]   insVa,
  input  logic [3:0]        insPs,
  input  logic [PPN_W-1:0]  insPpn,
  input  logic [2:0]        insRights,
  input  logic [1:0]        insPl,
  input  logic [KEY_W-1:0]  insKey,
  input  logic              purgeValid,
  input  logic [VA_W-1:0]   purgeVa,
  input  logic [3:0]        purgePs,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [1:0]        lkAccess,
  input  logic [1:0]        lkPl,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspMulti,
  output logic              rspAllow,
  output logic [PA_W-1:0]   rspPa
);

  tlbStrobes_t       strobes;
  logic [SLOT_W-1:0] insSlot;

  tlb_region_key_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rrWe       (rrWe),
    .keyWe      (keyWe),
    .insValid   (insValid),
    .purgeValid (purgeValid),
    .lkValid    (lkValid),
    .strobes    (strobes),
    .insSlot    (insSlot),
    .rspValid   (rspValid)
  );

  tlb_region_key_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .RID_W(RID_W), .KEY_W(KEY_W),
    .ENTRIES(ENTRIES), .KEYS(KEYS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .insSlot   (insSlot),
    .rrIdx     (rrIdx),
    .rrRid     (rrRid),
    .keyIdx    (keyIdx),
    .keyVal    (keyVal),
    .keyRights (keyRights),
    .keyValid  (keyValid),
    .insVa     (insVa),
    .insPs     (insPs),
    .insPpn    (insPpn),
    .insRights (insRights),
    .insPl     (insPl),
    .insKey    (insKey),
    .purgeVa   (purgeVa),
    .purgePs   (purgePs),
    .lkVa      (lkVa),
    .lkAccess  (lkAccess),
    .lkPl      (lkPl),
    .rspHit    (rspHit),
    .rspMiss   (rspMiss),
    .rspMulti  (rspMulti),
    .rspAllow  (rspAllow),
    .rspPa     (rspPa)
  );

endmodule

// File: rtl/tlb_region_key_chk.sv
module tlb_region_key_chk #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic [11:0]     lkVaLow,
  input logic            rspValid,
  input logic            rspHit,
  input logic            rspMiss,
  input logic            rspMulti,
  input logic            rspAllow,
  input logic [PA_W-1:0] rspPa
);

  assert_resp_follows_lookup_R2: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);

  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);

  assert_hit_miss_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspHit != rspMiss));

  assert_idle_flags_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspHit || rspMiss || rspMulti || rspAllow));

  assert_allow_needs_clean_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspAllow |-> (rspHit && !rspMulti));

  assert_multi_denied_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspMulti |-> (rspHit && !rspAllow));

  assert_offset_passthrough_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspPa[11:0] == $past(lkVaLow)));

endmodule

bind tlb_region_key tlb_region_key_chk #(.PA_W(PA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lkValid  (lkValid),
  .lkVaLow  (lkVa[11:0]),
  .rspValid (rspValid),
  .rspHit   (rspHit),
  .rspMiss  (rspMiss),
  .rspMulti (rspMulti),
  .rspAllow (rspAllow),
  .rspPa    (rspPa)
);

// File: tb/tlb_region_key_tb.sv
`timescale 1ns/1ps
module tlb_region_key_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rrWe;
  logic [2:0]  rrIdx;
  logic [23:0] rrRid;
  logic        keyWe;
  logic [2:0]  keyIdx;
  logic [23:0] keyVal;
  logic [2:0]  keyRights;
  logic        keyValid;
  logic        insValid;
  logic [63:0] insVa;
  logic [3:0]  insPs;
  logic [35:0] insPpn;
  logic [2:0]  insRights;
  logic [1:0]  insPl;
  logic [23:0] insKey;
  logic        purgeValid;
  logic [63:0] purgeVa;
  logic [3:0]  purgePs;
  logic        lkValid;
  logic [63:0] lkVa;
  logic [1:0]  lkAccess;
  logic [1:0]  lkPl;
  logic        rspValid, rspHit, rspMiss, rspMulti, rspAllow;
  logic [47:0] rspPa;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  tlb_region_key u_dut (
    .clk(clk), .rstN(rstN),
    .rrWe(rrWe), .rrIdx(rrIdx), .rrRid(rrRid),
    .keyWe(keyWe), .keyIdx(keyIdx), .keyVal(keyVal), .keyRights(keyRights), .keyValid(keyValid),
    .insValid(insValid), .insVa(insVa), .insPs(insPs), .insPpn(insPpn),
    .insRights(insRights), .insPl(insPl), .insKey(insKey),
    .purgeValid(purgeValid), .purgeVa(purgeVa), .purgePs(purgePs),
    .lkValid(lkValid), .lkVa(lkVa), .lkAccess(lkAccess), .lkPl(lkPl),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspMulti(rspMulti),
    .rspAllow(rspAllow), .rspPa(rspPa)
  );

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  acc;
    logic [1:0]  pl;
    logic        hit;
    logic        allow;
    logic [47:0] pa;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0040_0123, 2'd0, 2'd3, 1'b1, 1'b1, 48'h0000_ABCD_E123}, // R2 plain hit
    '{64'h4000_0000_0040_0ABC, 2'd0, 2'd0, 1'b1, 1'b1, 48'h0000_ABCD_EABC}, // R1 shared identifier
    '{64'h6000_0000_0040_0123, 2'd0, 2'd3, 1'b0, 1'b0, 48'h0},              // R1 other identifier
    '{64'h0000_0000_0041_0000, 2'd0, 2'd3, 1'b0, 1'b0, 48'h0},              // R3 page miss
    '{64'h0000_0000_0040_0000, 2'd1, 2'd3, 1'b1, 1'b0, 48'h0000_ABCD_E000}, // R5 key lacks write
    '{64'h2000_0000_001F_FFF8, 2'd0, 2'd0, 1'b1, 1'b1, 48'h0000_456F_FFF8}, // R4 1 MB page
    '{64'h2000_0000_001F_FFF8, 2'd2, 2'd0, 1'b1, 1'b1, 48'h0000_456F_FFF8}, // R6 execute allowed
    '{64'h2000_0000_001F_FFF8, 2'd1, 2'd0, 1'b1, 1'b0, 48'h0000_456F_FFF8}, // R6 entry lacks write
    '{64'h2000_0000_001F_FFF8, 2'd0, 2'd1, 1'b1, 1'b0, 48'h0000_456F_FFF8}, // R7 privilege too low
    '{64'h6000_0000_1ABC_DEF0, 2'd0, 2'd3, 1'b1, 1'b0, 48'h0001_2ABC_DEF0}, // R4 R5 256 MB, key invalid
    '{64'h0000_0000_0040_0123, 2'd3, 2'd3, 1'b1, 1'b0, 48'h0000_ABCD_E123}, // R5 access code 3
    '{64'h6000_0000_2000_0000, 2'd0, 2'd3, 1'b0, 1'b0, 48'h0}               // R4 next 256 MB page
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rrWe = 0; keyWe = 0; insValid = 0; purgeValid = 0; lkValid = 0;
  endtask

  task automatic wrRegion(input logic [2:0] idx, input logic [23:0] rid);
    @(negedge clk); rrWe = 1; rrIdx = idx; rrRid = rid;
    @(negedge clk); rrWe = 0;
  endtask

  task automatic wrKey(input logic [2:0] idx, input logic [23:0] key,
                       input logic [2:0] rights, input logic vld);
    @(negedge clk); keyWe = 1; keyIdx = idx; keyVal = key; keyRights = rights; keyValid = vld;
    @(negedge clk); keyWe = 0;
  endtask

  task automatic setIns(input logic [63:0] va, input logic [3:0] ps, input logic [35:0] ppn,
                        input logic [2:0] rights, input logic [1:0] pl, input logic [23:0] key);
    insValid = 1; insVa = va; insPs = ps; insPpn = ppn;
    insRights = rights; insPl = pl; insKey = key;
  endtask

  task automatic insert(input logic [63:0] va, input logic [3:0] ps, input logic [35:0] ppn,
                        input logic [2:0] rights, input logic [1:0] pl, input logic [23:0] key);
    @(negedge clk); setIns(va, ps, ppn, rights, pl, key);
    @(negedge clk); insValid = 0;
  endtask

  task automatic purge(input logic [63:0] va, input logic [3:0] ps);
    @(negedge clk); purgeValid = 1; purgeVa = va; purgePs = ps;
    @(negedge clk); purgeValid = 0;
  endtask

  // Response is registered at the edge after the request; sampled at the next falling edge.
  task automatic lookup(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] pl);
    @(negedge clk); lkValid = 1; lkVa = va; lkAccess = acc; lkPl = pl;
    @(negedge clk); lkValid = 0;
  endtask

  task automatic expectResp(input string tag, input logic hit, input logic allow,
                            input logic [47:0] pa);
    chk({tag, " valid"}, 64'(rspValid), 64'd1);
    chk({tag, " hit"},   64'(rspHit),   64'(hit));
    chk({tag, " miss"},  64'(rspMiss),  64'(!hit));
    chk({tag, " allow"}, 64'(rspAllow), 64'(allow));
    chk({tag, " pa"},    64'(rspPa),    64'(pa));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    idle();
    rrIdx = 0; rrRid = 0; keyIdx = 0; keyVal = 0; keyRights = 0; keyValid = 0;
    insVa = 0; insPs = 0; insPpn = 0; insRights = 0; insPl = 0; insKey = 0;
    purgeVa = 0; purgePs = 0; lkVa = 0; lkAccess = 0; lkPl = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R3: reset state and empty buffer
    @(negedge clk);
    chk("R3 reset valid", 64'(rspValid), 64'd0);
    chk("R3 reset hit",   64'(rspHit),   64'd0);
    lookup(64'h0000_0000_0040_0123, 2'd0, 2'd0);
    expectResp("R3 empty after reset", 1'b0, 1'b0, 48'h0);
    @(negedge clk);
    chk("R3 idle flags", 64'({rspValid, rspHit, rspMiss, rspAllow}), 64'd0);

    // Setup
    wrRegion(3'd0, 24'h000100);
    wrRegion(3'd1, 24'h000200);
    wrRegion(3'd2, 24'h000100);
    wrRegion(3'd3, 24'h000300);
    wrKey(3'd0, 24'h000011, 3'b001, 1'b1);
    wrKey(3'd1, 24'h000022, 3'b111, 1'b1);
    wrKey(3'd2, 24'h000044, 3'b111, 1'b0);
    insert(64'h0000_0000_0040_0000, 4'd0, 36'h0_000A_BCDE, 3'b111, 2'd3, 24'h000011); // slot 0
    insert(64'h2000_0000_0010_0000, 4'd5, 36'h0_0004_56AB, 3'b101, 2'd0, 24'h000022); // slot 1
    insert(64'h6000_0000_1000_0000, 4'd9, 36'h0_0012_0000, 3'b011, 2'd3, 24'h000044); // slot 2

    // Table of lookups
    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].va, VECS[i].acc, VECS[i].pl);
      expectResp($sformatf("vector %0d", i), VECS[i].hit, VECS[i].allow, VECS[i].pa);
    end

    // R1: rewriting a region identifier detaches that region
    wrRegion(3'd2, 24'h000555);
    lookup(64'h4000_0000_0040_0ABC, 2'd0, 2'd0);
    expectResp("R1 rewritten region", 1'b0, 1'b0, 48'h0);

    // R8: duplicate translation, 8 KB page over the same address, slot 3
    insert(64'h0000_0000_0040_0000, 4'd1, 36'h0_0001_1111, 3'b111, 2'd3, 24'h000022);
    lookup(64'h0000_0000_0040_0123, 2'd0, 2'd3);
    chk("R8 multi flag", 64'(rspMulti), 64'd1);
    chk("R8 hit",        64'(rspHit),   64'd1);
    chk("R8 denied",     64'(rspAllow), 64'd0);

    // R10: 4 KB purge removes both overlapping entries, leaves region1 alone
    purge(64'h0000_0000_0040_0000, 4'd0);
    lookup(64'h0000_0000_0040_0123, 2'd0, 2'd3);
    expectResp("R10 purged page", 1'b0, 1'b0, 48'h0);
    chk("R10 no multi", 64'(rspMulti), 64'd0);
    purge(64'h2000_0000_0030_0000, 4'd0);
    lookup(64'h2000_0000_001F_FFF8, 2'd0, 2'd0);
    expectResp("R10 non-overlapping purge", 1'b1, 1'b1, 48'h0000_456F_FFF8);
    purge(64'h6000_0000_0000_0000, 4'd10);
    lookup(64'h6000_0000_1ABC_DEF0, 2'd0, 2'd3);
    expectResp("R10 4 GB purge", 1'b0, 1'b0, 48'h0);
    lookup(64'h2000_0000_001F_FFF8, 2'd0, 2'd0);
    expectResp("R10 other region kept", 1'b1, 1'b1, 48'h0000_456F_FFF8);

    // R9: sixteen insertions starting at slot 4 wrap and overwrite slot 1
    for (int i = 0; i < 16; i++)
      insert(64'h6000_0001_0000_0000 + (64'(i) << 12), 4'd0, 36'(12'h100 + i), 3'b111, 2'd3, 24'h000022);
    lookup(64'h2000_0000_001F_FFF8, 2'd0, 2'd0);
    expectResp("R9 slot 1 overwritten", 1'b0, 1'b0, 48'h0);
    lookup(64'h6000_0001_0000_0034, 2'd0, 2'd3);
    expectResp("R9 first of wrap", 1'b1, 1'b1, 48'h0000_0010_0034);
    lookup(64'h6000_0001_0000_F034, 2'd0, 2'd3);
    expectResp("R9 last of wrap", 1'b1, 1'b1, 48'h0000_0010_F034);
    insert(64'h6000_0001_0001_0000, 4'd0, 36'h110, 3'b111, 2'd3, 24'h000022); // slot 4
    lookup(64'h6000_0001_0000_0034, 2'd0, 2'd3);
    expectResp("R9 oldest evicted", 1'b0, 1'b0, 48'h0);
    lookup(64'h6000_0001_0000_1034, 2'd0, 2'd3);
    expectResp("R9 neighbour kept", 1'b1, 1'b1, 48'h0000_0010_1034);

    // R11: purge and insertion in the same cycle
    @(negedge clk);
    purgeValid = 1; purgeVa = 64'h6000_0001_0000_0000; purgePs = 4'd10;
    setIns(64'h6000_0001_0080_0000, 4'd0, 36'h777, 3'b111, 2'd3, 24'h000022);
    @(negedge clk);
    purgeValid = 0; insValid = 0;
    lookup(64'h6000_0001_0000_2034, 2'd0, 2'd3);
    expectResp("R11 range purged", 1'b0, 1'b0, 48'h0);
    lookup(64'h6000_0001_0080_0010, 2'd0, 2'd3);
    expectResp("R11 insert survives", 1'b1, 1'b1, 48'h0000_0077_7010);

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule